// File: doc/BRIEF.md
# Serial Debug Command Sequencer

This block sits behind a debug port that moves 16-bit words, one word in and one word out on each shift. It decodes each incoming command word, collects the operand words a control-register read needs, and asks a bank of control registers for a value through a simple request/acknowledge interface. It then hands the result back on later shifts. The protocol is pipelined: the frame shifted out during a shift is the answer to earlier traffic, never to the word being shifted in at that moment.

Each outgoing frame has 17 bits: a status bit (bit 16) and 16 data bits. The status bit is clear for results and for the command-complete word, and set for the not-ready and error words. A no-operation command produces an all-ones complete word. A control-register read always produces 32 bits, returned as two halves. The register is selected by a 12-bit code taken from the low bits of a two-word address. Registers narrower than 32 bits are zero-extended.

Top module: `sdbg_seq`

## Requirements
- R1: After a synchronous active-low reset, the outgoing frame is not-ready (status 1, data 0x0000), and no register read is requested.
- R2: A command word of 0x0000 is a no-operation. It issues no read, and the next shift returns the complete frame (status 0, data 0xFFFF).
- R3: The outgoing frame changes only after a shift or after a read acknowledge. Between those events it holds its value.
- R4: Command word 0x2980 starts a control-register read that takes two more words, the upper address word first. The shifts that follow the opcode and the upper word return not-ready.
- R5: Bits 11:0 of the second address word drive rd_code, and bits 15:12 of that word and the whole upper word are ignored. rd_req stays high, with rd_code stable, until rd_ack.
- R6: While a read is pending, every shift returns not-ready, and the word shifted in is ignored.
- R7: After rd_ack, the next two shifts return the result with status 0: bits 31:16 first, then bits 15:0.
- R8: The result is zero-extended to the width of the selected register. SR (0x80E) and MASK (0x805) are 16 bits, MACSR (0x804) is 8 bits, and the other mapped codes are 32 bits.
- R9: A code outside the map (0x002, 0x004, 0x005, 0x801, 0x804, 0x805, 0x806, 0x80E, 0x80F, 0xC04, 0xC0F) issues no read. The next shift returns error (status 1, data 0x0001), and the sequencer then waits for a command.
- R10: Any other command word returns error on the next shift, and the sequencer then waits for a command.
- R11: The word shifted in with the upper result half is ignored. The word shifted in with the lower result half is decoded as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sh_valid | input | 1 | A word shift takes place this cycle |
| sh_word | input | 16 | Word shifted in from the host |
| rsp_stat | output | 1 | Status bit of the frame being shifted out |
| rsp_data | output | 16 | Data of the frame being shifted out |
| rd_req | output | 1 | Control-register read request, held until acknowledged |
| rd_code | output | 12 | Register select code for the read |
| rd_ack | input | 1 | Read completed; rd_data valid this cycle |
| rd_data | input | 32 | Raw register value from the bank |

## Verification
The bench goes after the one-shift lag: a design that answered the current word at once would show complete or error frames one shift early. It checks that the word shifted in alongside the upper result half is dropped, while the word shifted in with the lower half starts a new command; a design that decoded the wrong one would start a read or report an error out of place. It feeds narrow registers with all-ones upper bits, so a missing zero-extension shows up as stray high bits. It holds off the acknowledge and shifts during the wait, so a design that left the wait early, or took that word as a command, returns the wrong frame. An unmapped code must raise the error without a request, which the bench counts.

// File: rtl/sdbg_pkg.sv
// Package: shared constants, types and the register map for the debug sequencer.
// Assumes 16-bit words, a 12-bit register code and a 32-bit result.
package sdbg_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned CODE_W = 12;
    localparam int unsigned RES_W  = 2 * WORD_W;
    localparam int unsigned FRM_W  = WORD_W + 1;

    localparam logic [WORD_W-1:0] OP_NOP   = 16'h0000;
    localparam logic [WORD_W-1:0] OP_CRRD  = 16'h2980;

    localparam logic [FRM_W-1:0] FRM_NOTRDY = {1'b1, 16'h0000};
    localparam logic [FRM_W-1:0] FRM_DONE   = {1'b0, 16'hFFFF};
    localparam logic [FRM_W-1:0] FRM_ERR    = {1'b1, 16'h0001};

    typedef enum logic [1:0] {K_NOP, K_CRRD, K_BAD} cmd_kind_t;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR_HI, S_ADDR_LO, S_WAIT, S_RES_HI, S_RES_LO
    } seq_state_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [5:0]        width;
    } map_ent_t;

    localparam int unsigned MAP_N = 11;

    localparam map_ent_t REG_MAP [MAP_N] = '{
        '{12'h002, 6'd32}, '{12'h004, 6'd32}, '{12'h005, 6'd32},
        '{12'h801, 6'd32}, '{12'h804, 6'd8},  '{12'h805, 6'd16},
        '{12'h806, 6'd32}, '{12'h80E, 6'd16}, '{12'h80F, 6'd32},
        '{12'hC04, 6'd32}, '{12'hC0F, 6'd32}
    };

endpackage

// File: rtl/sdbg_cmd_decode.sv
// Command decoder: classifies a command word as no-op, control-register read or bad.
// Assumes only the two defined opcodes; all other words are bad.
module sdbg_cmd_decode
    import sdbg_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output cmd_kind_t         kind_o
);

    // Map the word onto a command kind.
    always_comb begin
        if (word_i == OP_NOP)       kind_o = K_NOP;
        else if (word_i == OP_CRRD) kind_o = K_CRRD;
        else                        kind_o = K_BAD;
    end

endmodule

// File: rtl/sdbg_regmap.sv
// Register map lookup: reports whether a code is mapped and gives the
// zero-extension mask for its width. Assumes a sparse map from the package.
module sdbg_regmap
    import sdbg_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic              hit_o,
    output logic [RES_W-1:0]  mask_o
);

    // Search the map for the code and build the mask from its width.
    always_comb begin
        hit_o  = 1'b0;
        mask_o = '0;
        for (int i = 0; i < MAP_N; i++) begin
            if (REG_MAP[i].code == code_i) begin
                hit_o = 1'b1;
                if (int'(REG_MAP[i].width) >= RES_W)
                    mask_o = '1;
                else
                    mask_o = (RES_W'(1) << REG_MAP[i].width) - RES_W'(1);
            end
        end
    end

endmodule

// File: rtl/sdbg_seq.sv
// Debug command sequencer top. It decodes word commands, collects the
// two address words of a control-register read, requests the register and
// returns frames one shift late. Assumes rd_ack arrives only while rd_req is high.
module sdbg_seq
    import sdbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sh_valid,
    input  logic [15:0]       sh_word,
    output logic              rsp_stat,
    output logic [15:0]       rsp_data,
    output logic              rd_req,
    output logic [11:0]       rd_code,
    input  logic              rd_ack,
    input  logic [31:0]       rd_data
);

    seq_state_t          st;
    logic [FRM_W-1:0]    frame;
    logic [WORD_W-1:0]   lo_hold;
    logic [CODE_W-1:0]   code_q;
    cmd_kind_t           kind;
    logic [CODE_W-1:0]   look_code;
    logic                map_hit;
    logic [RES_W-1:0]    map_mask;
    logic [RES_W-1:0]    masked;

    sdbg_cmd_decode u_dec (
        .word_i (sh_word),
        .kind_o (kind)
    );

    // Look up the incoming code while it arrives, and the held code afterwards.
    assign look_code = (st == S_ADDR_LO) ? sh_word[CODE_W-1:0] : code_q;

    sdbg_regmap u_map (
        .code_i (look_code),
        .hit_o  (map_hit),
        .mask_o (map_mask)
    );

    // Zero-extend the returned value to the register width.
    assign masked = rd_data & map_mask;

    // Sequencer state, outgoing frame and held result half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            frame   <= FRM_NOTRDY;
            lo_hold <= '0;
            code_q  <= '0;
        end else begin
            case (st)
                S_IDLE, S_RES_LO: begin
                    if (sh_valid) begin
                        case (kind)
                            K_NOP: begin
                                frame <= FRM_DONE;
                                st    <= S_IDLE;
                            end
                            K_CRRD: begin
                                frame <= FRM_NOTRDY;
                                st    <= S_ADDR_HI;
                            end
                            default: begin
                                frame <= FRM_ERR;
                                st    <= S_IDLE;
                            end
                        endcase
                    end
                end
                S_ADDR_HI: begin
                    if (sh_valid) st <= S_ADDR_LO;
                end
                S_ADDR_LO: begin
                    if (sh_valid) begin
                        code_q <= sh_word[CODE_W-1:0];
                        if (map_hit) begin
                            st <= S_WAIT;
                        end else begin
                            frame <= FRM_ERR;
                            st    <= S_IDLE;
                        end
                    end
                end
                S_WAIT: begin
                    if (rd_ack) begin
                        frame   <= {1'b0, masked[RES_W-1:WORD_W]};
                        lo_hold <= masked[WORD_W-1:0];
                        st      <= S_RES_HI;
                    end
                end
                S_RES_HI: begin
                    if (sh_valid) begin
                        frame <= {1'b0, lo_hold};
                        st    <= S_RES_LO;
                    end
                end
                default: begin
                    st    <= S_IDLE;
                    frame <= FRM_NOTRDY;
                end
            endcase
        end
    end

    // Drive the ports from the held state.
    assign rsp_stat = frame[FRM_W-1];
    assign rsp_data = frame[WORD_W-1:0];
    assign rd_req   = (st == S_WAIT);
    assign rd_code  = code_q;

    // R2: a no-op taken at a command slot gives the complete frame next.
    a_r2_nop_done: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_valid && (st == S_IDLE || st == S_RES_LO) && sh_word == OP_NOP)
        |=> ({rsp_stat, rsp_data} == FRM_DONE && !rd_req));

    // R3: the frame is quiet without a shift or acknowledge.
    a_r3_frame_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_valid && !rd_ack) |=> $stable({rsp_stat, rsp_data}));

    // R5: the request is held with a stable code until acknowledged.
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_code)));

    // R6: a pending read always shows not-ready.
    a_r6_wait_notready: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rsp_stat && rsp_data == 16'h0000));

    // R9: an unmapped code never raises a request.
    a_r9_no_req_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ADDR_LO && sh_valid && !map_hit) |=> (!rd_req && rsp_stat && rsp_data == 16'h0001));

    // R7: result frames carry a clear status bit.
    a_r7_result_status: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack) |=> !rsp_stat);

endmodule

// File: tb/sdbg_seq_bench.sv
// Bench for the debug command sequencer: a vector table walked by one loop,
// then directed tests for reset, held acknowledge and quiet frames.
module sdbg_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sh_valid = 1'b0;
    logic [15:0] sh_word = 16'h0000;
    logic        rsp_stat;
    logic [15:0] rsp_data;
    logic        rd_req;
    logic [11:0] rd_code;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = 32'h0;

    int checks = 0;
    int fails  = 0;
    int acks   = 0;
    int wait_cnt = 0;
    logic ack_hold = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdbg_seq u_sdbg_seq (
        .clk(clk), .rst_n(rst_n), .sh_valid(sh_valid), .sh_word(sh_word),
        .rsp_stat(rsp_stat), .rsp_data(rsp_data), .rd_req(rd_req),
        .rd_code(rd_code), .rd_ack(rd_ack), .rd_data(rd_data)
    );

    // Bank model: acknowledges three cycles into a request with {D,code,E,code}.
    initial forever begin
        @(negedge clk);
        rd_ack = 1'b0;
        if (rd_req && !ack_hold) begin
            wait_cnt++;
            if (wait_cnt == 3) begin
                rd_ack   = 1'b1;
                rd_data  = {4'hD, rd_code, 4'hE, rd_code};
                wait_cnt = 0;
                acks++;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // One shift: the frame seen while the word goes in is the one shifted out.
    task automatic shift(input logic [15:0] w, input string req, input logic [16:0] exp);
        logic [16:0] got;
        @(negedge clk);
        sh_valid = 1'b1;
        sh_word  = w;
        got = {rsp_stat, rsp_data};
        @(negedge clk);
        sh_valid = 1'b0;
        check(req, 32'(got), 32'(exp));
        repeat (8) @(negedge clk);
    endtask

    localparam logic [16:0] NR   = 17'h1_0000;
    localparam logic [16:0] DONE = 17'h0_FFFF;
    localparam logic [16:0] ERR  = 17'h1_0001;

    // Columns: word in, expected frame out.
    localparam int NV = 23;
    localparam logic [32:0] VEC [NV] = '{
        {16'h0000, NR},            // R1 reset frame
        {16'h0000, DONE},          // R2
        {16'h2980, DONE},
        {16'h1234, NR},            // R4
        {16'h0801, NR},            // R4 VBR
        {16'h2980, 17'h0_D801},    // R7 hi, R11 ignored
        {16'h0000, 17'h0_E801},    // R7 lo, R11 decoded
        {16'h2980, DONE},
        {16'h0000, NR},
        {16'h0804, NR},            // MACSR
        {16'h0000, 17'h0_0000},    // R8 8-bit
        {16'h1111, 17'h0_0004},    // R8
        {16'h0000, ERR},           // R10
        {16'h2980, DONE},
        {16'h0000, NR},
        {16'h0123, NR},            // unmapped
        {16'h0000, ERR},           // R9
        {16'h2980, DONE},
        {16'hFFFF, NR},
        {16'hF80E, NR},            // SR, bits 15:12 ignored (R5)
        {16'h0000, 17'h0_0000},    // R8 16-bit
        {16'h0000, 17'h0_E80E},
        {16'h0000, DONE}
    };

    initial begin
        repeat (4) @(negedge clk);
        check("R1 stat", 32'(rsp_stat), 32'h1);
        check("R1 data", 32'(rsp_data), 32'h0);
        check("R1 req", 32'(rd_req), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++)
            shift(VEC[i][32:17], "R2/R4/R7/R8/R9/R10/R11 table", VEC[i][16:0]);
        check("R9 no request for unmapped", 32'(acks), 32'd3);

        // R5/R6: hold the acknowledge and shift during the wait.
        ack_hold = 1'b1;
        shift(16'h2980, "R4", DONE);
        shift(16'hABCD, "R4", NR);
        shift(16'h1C0F, "R5", NR);
        check("R5 req", 32'(rd_req), 32'h1);
        check("R5 code", 32'(rd_code), 32'hC0F);
        shift(16'h2980, "R6 wait", NR);
        check("R6 still waiting", 32'(rd_req), 32'h1);
        check("R5 code stable", 32'(rd_code), 32'hC0F);
        ack_hold = 1'b0;
        repeat (6) @(negedge clk);
        check("R5 req dropped", 32'(rd_req), 32'h0);
        shift(16'h0000, "R7 hi", 17'h0_DC0F);
        shift(16'h0000, "R7 lo", 17'h0_EC0F);
        // R3: frame holds over idle cycles.
        repeat (20) @(negedge clk);
        check("R3 quiet", 32'({rsp_stat, rsp_data}), 32'(DONE));
        check("R2 no request", 32'(rd_req), 32'h0);
        shift(16'h0000, "R3", DONE);

        // R1: reset mid-command.
        shift(16'h2980, "R4", DONE);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        shift(16'h0000, "R1 after reset", NR);
        shift(16'h0000, "R1 idle", DONE);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog got=hung exp=finished");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule